// File: doc/BRIEF.md
# Parity-Protected Instruction Store Loader

This block is the host-side write path into an engine's instruction store. Software opens a programming window through an index register and gives the starting entry. It then pushes 40-bit instructions as two 32-bit register writes, the low word first. The second write of each pair commits the instruction to an internal array and advances the index. Each stored word carries two even-parity bits, one for each 20-bit half of the instruction. A context-control register holds the enable for parity checking.

On the engine side, a fetch port reads any entry with one cycle of latency. It returns the instruction and its stored parity bits. It raises an error flag when checking is enabled and a stored parity bit disagrees with the value recomputed from the instruction. The index register can be read back, so software can see where the next instruction will land and can detect that the index has wrapped.

Top module: `cstore_loader`

## Requirements
- R1: Register offsets: index register 0x000, low-word register 0x004, high-word register 0x008, context-control register 0x018. A read of 0x000 or 0x018 returns that register. A read of any other offset returns 0.
- R2: A write to 0x000 with bit 31 set enters programming mode with the index taken from bits 11:0. A write with bit 31 clear, such as 0, leaves programming mode. A read of 0x000 returns bit 31 equal to the mode, bits 11:0 equal to the index, and zeros elsewhere.
- R3: The committed instruction takes bits 31:0 from the most recent low-word write and bits 39:32 from bits 7:0 of the high-word write. Bits 31:8 of the high-word write are ignored.
- R4: A high-word write in programming mode stores the word at the current index, and the index reads back one higher from the next cycle on.
- R5: Committing at entry 4095 wraps the index to 0, and the index register then reads 0x80000000.
- R6: Stored bit 40 is the XOR of instruction bits 19:0, and stored bit 41 is the XOR of instruction bits 39:20. The fetch port presents them as fetch_par = {bit 41, bit 40}.
- R7: A high-word write outside programming mode changes neither the array nor the index.
- R8: A low-word write with no following high-word write leaves the array unchanged. A later low-word write replaces the latched low word.
- R9: When fetch_en is high, the entry at fetch_idx appears on fetch_insn and fetch_par one cycle later. While fetch_en is low, those outputs hold.
- R10: fetch_perr can be high only when bit 28 of the context-control register is set and a stored parity bit mismatches. It stays low for every word written through the loader, with checking enabled or disabled.
- R11: After reset the block is out of programming mode, the index and the context-control register are 0, and the fetch outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 9 | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data for csr_addr (combinational) |
| fetch_en | input | 1 | Fetch request |
| fetch_idx | input | 12 | Entry to fetch |
| fetch_insn | output | 40 | Fetched instruction |
| fetch_par | output | 2 | Stored parity bits of the fetched entry |
| fetch_perr | output | 1 | Parity mismatch with checking enabled |

## Verification
Register writes take effect at the clock edge that samples the strobe. The bench therefore reads a register back combinationally in the low phase after that edge, with no extra wait. A fetch result is registered, so the bench raises fetch_en in one low phase and compares fetch_insn, fetch_par and fetch_perr in the next low phase, one edge later. A fetch is only issued after the commit edge of the entry it reads. Random register traffic over a small window of entries is checked against a bench model of the mode, the index, the latched low word and the array contents. Directed cases cover index wrap, ignored high-word writes and a dangling low-word write.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int CSR_AW  = 9;
    localparam int INSN_W  = 40;
    localparam int HALF_W  = INSN_W / 2;
    localparam int WORD_W  = INSN_W + 2;

    localparam logic [CSR_AW-1:0] OFS_INDEX = 9'h000;
    localparam logic [CSR_AW-1:0] OFS_LOW   = 9'h004;
    localparam logic [CSR_AW-1:0] OFS_HIGH  = 9'h008;
    localparam logic [CSR_AW-1:0] OFS_CTX   = 9'h018;

    localparam int CTX_PAR_BIT = 28;

    // {parity of upper half, parity of lower half}
    function automatic logic [1:0] half_parity(input logic [INSN_W-1:0] insn);
        return {^insn[INSN_W-1:HALF_W], ^insn[HALF_W-1:0]};
    endfunction

endpackage

// File: rtl/cs_csr_regs.sv
module cs_csr_regs
    import cs_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 csr_we,
    input  logic [CSR_AW-1:0]    csr_addr,
    input  logic [31:0]          csr_wdata,
    output logic [31:0]          csr_rdata,
    output logic                 commit,
    output logic [IDX_W-1:0]     commit_idx,
    output logic [WORD_W-1:0]    commit_word,
    output logic                 chk_en
);

    localparam int PAD_W = 31 - IDX_W;

    typedef struct packed {
        logic             prog;
        logic [IDX_W-1:0] idx;
        logic [31:0]      low;
        logic [31:0]      ctx;
    } regs_t;

    regs_t s_d, s_q;
    logic  commit_d;
    logic [INSN_W-1:0] insn_d;

    always_comb begin
        s_d      = s_q;
        commit_d = 1'b0;
        insn_d   = {csr_wdata[7:0], s_q.low};
        if (csr_we) begin
            case (csr_addr)
                OFS_INDEX: begin
                    s_d.prog = csr_wdata[31];
                    s_d.idx  = csr_wdata[IDX_W-1:0];
                end
                OFS_LOW: begin
                    s_d.low = csr_wdata;
                end
                OFS_HIGH: begin
                    if (s_q.prog) begin
                        commit_d = 1'b1;
                        s_d.idx  = s_q.idx + 1'b1;
                    end
                end
                OFS_CTX: begin
                    s_d.ctx = csr_wdata;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        case (csr_addr)
            OFS_INDEX: csr_rdata = {s_q.prog, {PAD_W{1'b0}}, s_q.idx};
            OFS_CTX:   csr_rdata = s_q.ctx;
            default:   csr_rdata = '0;
        endcase
    end

    assign commit      = commit_d;
    assign commit_idx  = s_q.idx;
    assign commit_word = {half_parity(insn_d), insn_d};
    assign chk_en      = s_q.ctx[CTX_PAR_BIT];

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == OFS_HIGH && s_q.prog)
        |=> (s_q.idx == IDX_W'($past(s_q.idx) + 1'b1)) && s_q.prog); // R4

    AST_HIGH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == OFS_HIGH && !s_q.prog)
        |=> $stable(s_q.idx) && !s_q.prog); // R7

    AST_INDEX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == OFS_HIGH && s_q.prog && (&s_q.idx))
        |=> (s_q.idx == '0) && s_q.prog); // R5

    AST_PROG_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr == OFS_INDEX && !csr_wdata[31])
        |=> !s_q.prog); // R2

endmodule

// File: rtl/cs_store_ram.sv
module cs_store_ram
    import cs_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [WORD_W-1:0]  wr_data,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [WORD_W-1:0]  rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            rd_d = mem[rd_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data = rd_q;

    AST_WR_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data[INSN_W] == ^wr_data[HALF_W-1:0])
              && (wr_data[INSN_W+1] == ^wr_data[INSN_W-1:HALF_W])); // R6

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_q)); // R9

endmodule

// File: rtl/cs_fetch_chk.sv
module cs_fetch_chk
    import cs_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    input  logic              chk_en,
    output logic [INSN_W-1:0] insn,
    output logic [1:0]        par,
    output logic              perr
);

    logic [1:0] recomputed;

    always_comb begin
        insn       = word[INSN_W-1:0];
        par        = word[WORD_W-1:INSN_W];
        recomputed = half_parity(word[INSN_W-1:0]);
        perr       = chk_en && (recomputed != par);
    end

endmodule

// File: rtl/cstore_loader.sv
module cstore_loader
    import cs_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 csr_we,
    input  logic [8:0]           csr_addr,
    input  logic [31:0]          csr_wdata,
    output logic [31:0]          csr_rdata,
    input  logic                 fetch_en,
    input  logic [IDX_W-1:0]     fetch_idx,
    output logic [39:0]          fetch_insn,
    output logic [1:0]           fetch_par,
    output logic                 fetch_perr
);

    logic              commit;
    logic [IDX_W-1:0]  commit_idx;
    logic [WORD_W-1:0] commit_word;
    logic              chk_en;
    logic [WORD_W-1:0] rd_word;

    cs_csr_regs #(.IDX_W(IDX_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_we      (csr_we),
        .csr_addr    (csr_addr),
        .csr_wdata   (csr_wdata),
        .csr_rdata   (csr_rdata),
        .commit      (commit),
        .commit_idx  (commit_idx),
        .commit_word (commit_word),
        .chk_en      (chk_en)
    );

    cs_store_ram #(.IDX_W(IDX_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_idx  (commit_idx),
        .wr_data (commit_word),
        .rd_en   (fetch_en),
        .rd_idx  (fetch_idx),
        .rd_data (rd_word)
    );

    cs_fetch_chk u_chk (
        .word   (rd_word),
        .chk_en (chk_en),
        .insn   (fetch_insn),
        .par    (fetch_par),
        .perr   (fetch_perr)
    );

    AST_PERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |-> !fetch_perr); // R10

endmodule

// File: tb/test_cstore_loader.sv
module test_cstore_loader;

    localparam int IDX_W = 12;
    localparam int DEPTH = 1 << IDX_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             csr_we = 1'b0;
    logic [8:0]       csr_addr = '0;
    logic [31:0]      csr_wdata = '0;
    logic [31:0]      csr_rdata;
    logic             fetch_en = 1'b0;
    logic [IDX_W-1:0] fetch_idx = '0;
    logic [39:0]      fetch_insn;
    logic [1:0]       fetch_par;
    logic             fetch_perr;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // bench model
    bit               m_prog = 1'b0;
    bit [IDX_W-1:0]   m_idx = '0;
    bit [31:0]        m_low = '0;
    bit [31:0]        m_ctx = '0;
    bit [41:0]        mdl [DEPTH];
    bit               written [DEPTH];

    always #5 clk = ~clk;

    cstore_loader #(.IDX_W(IDX_W)) i_cstore_loader (
        .clk        (clk),
        .rst_n      (rst_n),
        .csr_we     (csr_we),
        .csr_addr   (csr_addr),
        .csr_wdata  (csr_wdata),
        .csr_rdata  (csr_rdata),
        .fetch_en   (fetch_en),
        .fetch_idx  (fetch_idx),
        .fetch_insn (fetch_insn),
        .fetch_par  (fetch_par),
        .fetch_perr (fetch_perr)
    );

    function automatic bit [1:0] exp_par(input bit [39:0] w);
        bit lo = 1'b0;
        bit hi = 1'b0;
        for (int i = 0; i < 20; i++) lo = lo ^ w[i];
        for (int i = 20; i < 40; i++) hi = hi ^ w[i];
        return {hi, lo};
    endfunction

    function automatic bit [31:0] exp_index();
        return {m_prog, 19'b0, m_idx};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we    = 1'b1;
        csr_addr  = a;
        csr_wdata = d;
        @(negedge clk);
        csr_we    = 1'b0;
    endtask

    task automatic wr_index(input bit [31:0] d);
        wr(9'h000, d);
        m_prog = d[31];
        m_idx  = d[IDX_W-1:0];
    endtask

    task automatic wr_low(input bit [31:0] d);
        wr(9'h004, d);
        m_low = d;
    endtask

    task automatic wr_high(input bit [31:0] d);
        bit [39:0] w;
        wr(9'h008, d);
        if (m_prog) begin
            w = {d[7:0], m_low};
            mdl[m_idx]     = {exp_par(w), w};
            written[m_idx] = 1'b1;
            m_idx          = m_idx + 1'b1;
        end
    endtask

    task automatic wr_ctx(input bit [31:0] d);
        wr(9'h018, d);
        m_ctx = d;
    endtask

    task automatic rd_chk(input string req, input logic [8:0] a, input bit [31:0] exp);
        csr_we   = 1'b0;
        csr_addr = a;
        #1;
        chk(req, {32'b0, csr_rdata}, {32'b0, exp});
    endtask

    task automatic fetch_chk(input string req, input bit [IDX_W-1:0] i);
        @(negedge clk);
        fetch_en  = 1'b1;
        fetch_idx = i;
        @(negedge clk);
        fetch_en  = 1'b0;
        #1;
        chk({req, " insn"}, {24'b0, fetch_insn}, {24'b0, mdl[i][39:0]});
        chk({req, " par"}, {62'b0, fetch_par}, {62'b0, mdl[i][41:40]});
        chk({req, " perr"}, {63'b0, fetch_perr}, 64'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R11: reset state
        rd_chk("R11 index", 9'h000, 32'h0);
        rd_chk("R11 ctx", 9'h018, 32'h0);
        chk("R11 fetch_insn", {24'b0, fetch_insn}, 64'b0);
        chk("R11 fetch_perr", {63'b0, fetch_perr}, 64'b0);

        // R1: register map and read-back
        wr_ctx(32'h1234_5678);
        rd_chk("R1 ctx readback", 9'h018, 32'h1234_5678);
        rd_chk("R1 low unreadable", 9'h004, 32'h0);
        rd_chk("R1 high unreadable", 9'h008, 32'h0);
        wr_ctx(32'h0);

        // R2: enter and leave programming mode
        wr_index(32'h8000_0005);
        rd_chk("R2 enter", 9'h000, 32'h8000_0005);
        wr_index(32'h0);
        rd_chk("R2 exit", 9'h000, 32'h0);

        // R5: wrap past the last entry
        wr_index(32'h8000_0FFE);
        wr_low(32'hDEAD_BEEF); wr_high(32'h0000_00A1);
        rd_chk("R4 advance", 9'h000, 32'h8000_0FFF);
        wr_low(32'h0F0F_0001); wr_high(32'h0000_0010);
        rd_chk("R5 wrap", 9'h000, 32'h8000_0000);
        wr_low(32'h0000_0001); wr_high(32'h0000_0000);
        rd_chk("R4 after wrap", 9'h000, 32'h8000_0001);
        fetch_chk("R5 entry 4094", 12'hFFE);
        fetch_chk("R5 entry 4095", 12'hFFF);
        fetch_chk("R6 entry 0", 12'h000);
        chk("R6 known parity", {62'b0, fetch_par}, {62'b0, 2'b01});

        // R3 / R8: assembly and dangling low writes
        wr_index(32'h8000_0010);
        wr_low(32'hAAAA_5555); wr_high(32'hFFFF_FF5A);
        rd_chk("R4 idx 17", 9'h000, 32'h8000_0011);
        wr_low(32'h1111_1111); wr_low(32'h2222_2222); wr_high(32'h0000_0033);
        wr_low(32'h3333_4444); wr_high(32'h0000_00C7);
        wr_index(32'h8000_0012);
        wr_low(32'h9999_9999);
        wr_index(32'h0);
        fetch_chk("R3 entry 16", 12'h010);
        chk("R3 upper byte only", {24'b0, fetch_insn}, {24'b0, 8'h5A, 32'hAAAA_5555});
        fetch_chk("R8 replaced low", 12'h011);
        chk("R8 second low wins", {24'b0, fetch_insn}, {24'b0, 8'h33, 32'h2222_2222});
        fetch_chk("R8 dangling low", 12'h012);

        // R7: high write outside programming mode
        wr_high(32'h0000_0077);
        rd_chk("R7 index held", 9'h000, 32'h0);
        fetch_chk("R7 entry 0 kept", 12'h000);

        // R9: outputs hold while fetch_en low
        fetch_chk("R9 fetch 16", 12'h010);
        @(negedge clk); @(negedge clk);
        chk("R9 hold", {24'b0, fetch_insn}, {24'b0, mdl[16][39:0]});

        // R10: checking enabled, loader-written words never flag
        wr_ctx(32'h1000_0000);
        fetch_chk("R10 chk on 4094", 12'hFFE);
        fetch_chk("R10 chk on 17", 12'h011);

        // random traffic over entries 0..31
        for (int n = 0; n < 400; n++) begin
            int op;
            op = $urandom_range(0, 9);
            case (op)
                0, 1: wr_low($urandom());
                2, 3: wr_high($urandom());
                4: wr_index(($urandom_range(0, 3) == 0) ? 32'h0
                            : (32'h8000_0000 | 32'($urandom_range(0, 31))));
                5: wr_ctx($urandom() & 32'h1000_00FF);
                6, 7: begin
                    bit [IDX_W-1:0] k;
                    k = IDX_W'($urandom_range(0, 31));
                    if (written[k]) fetch_chk("R9 R6 R10 random fetch", k);
                end
                default: rd_chk("R2 R4 random index", 9'h000, exp_index());
            endcase
        end
        rd_chk("R1 random ctx", 9'h018, m_ctx);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule